// File: doc/BRIEF.md
# Jitter Buffer Slip Detector

This block owns the write pointers of a set of 2048-byte circular reassembly buffers, one per channel. A TDM engine outside the block drains each buffer. The buffer RAM, the TDM read engine and any statistics counters are outside the block. Before each 47-byte cell goes into a channel's buffer, the caller raises a request. The request carries the channel number, that channel's current TDM read pointer and the channel's maximum lead. The block answers one cycle later with the byte address where the cell must start. When the write would have slipped, it also sends a one-cycle error pulse on that channel's overflow or underrun bit.

The maximum lead sets how far the writer may run ahead of the reader, so it sets how much cell delay variation the buffer tolerates. The first cell of a channel is placed half a maximum lead ahead of the reader. After every slip the writer is pulled back to that same centre point, so that one burst of delay variation does not cause a chain of slips. Filler cells and received cells go through exactly the same check.

Top module: `jbuf_slip_top`

## Requirements
- R1: While rst_ni is low, wr_vld_o is 0 and every bit of ovf_o and udr_o is 0.
- R2: The first request on a channel after reset returns wr_addr_o = (rd_ptr_i + max_lead_i/2) mod 2048 (integer halving) and raises no error bit.
- R3: For a request on a channel that has already written a cell, define lead = (stored write pointer − rd_ptr_i) mod 2048. If 0 < lead < 1024 and lead + 47 ≤ max_lead_i, the result is okay: wr_addr_o equals the stored pointer and no error bit is raised.
- R4: If 0 < lead < 1024 and lead + 47 > max_lead_i, the write is an overflow. Bit ch of ovf_o is raised and wr_addr_o is recentred to (rd_ptr_i + max_lead_i/2) mod 2048.
- R5: If lead = 0 or lead ≥ 1024, the writer is on or behind the reader, which is an underrun. Bit ch of udr_o is raised and wr_addr_o is recentred to (rd_ptr_i + max_lead_i/2) mod 2048.
- R6: An error bit is high for exactly one cycle, only together with wr_vld_o, and at most one bit across ovf_o and udr_o is high at a time.
- R7: Each channel keeps its own write pointer and first-cell state. Requests on one channel never change the result of another channel.
- R8: After every accepted request, the channel's stored pointer becomes (wr_addr_o + 47) mod 2048. All pointer arithmetic wraps at 2048.
- R9: wr_vld_o is high in the cycle after a cycle in which cell_req_i was high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_req_i | input | 1 | A cell is about to be written |
| cell_ch_i | input | 3 | Channel of the cell |
| rd_ptr_i | input | 11 | Current TDM read pointer of that channel |
| max_lead_i | input | 11 | Maximum lead of that channel, in bytes (below 1024) |
| wr_vld_o | output | 1 | The result below is valid |
| wr_addr_o | output | 11 | Start byte address for the cell |
| ovf_o | output | 8 | Per-channel overflow pulse |
| udr_o | output | 8 | Per-channel underrun pulse |

## Verification
The hardest case to reach is an okay write that lands exactly on the boundary, lead + 47 = max_lead. Close behind it come the two underrun edges: lead exactly zero, and a pointer that has just wrapped past 2047. Every step after the first cell shifts the stored pointer by 47, so hitting these edges means keeping the read pointer fixed while cells accumulate. The bench does this in a directed sequence and also sets the read pointer equal to the stored pointer. A random phase then places the read pointer at an offset from the model's pointer, chosen in a window that covers both sides of zero and the maximum-lead boundary.

// File: rtl/jbuf_slip_pkg.sv
package jbuf_slip_pkg;
  typedef enum logic [1:0] {
    VERD_INIT = 2'd0,
    VERD_OK   = 2'd1,
    VERD_OVF  = 2'd2,
    VERD_UDR  = 2'd3
  } verdict_e;
endpackage

// File: rtl/jbuf_slip_class.sv
module jbuf_slip_class
  import jbuf_slip_pkg::*;
#(
  parameter int PTR_W      = 11,
  parameter int CELL_BYTES = 47
) (
  input  logic             primed_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  input  logic [PTR_W-1:0] max_lead_i,
  output verdict_e         verdict_o,
  output logic [PTR_W-1:0] start_o,
  output logic [PTR_W-1:0] next_ptr_o
);
  localparam logic [PTR_W:0]   CELL_EXT = (PTR_W+1)'(CELL_BYTES);
  localparam logic [PTR_W-1:0] CELL_PTR = PTR_W'(CELL_BYTES);

  logic [PTR_W-1:0] lead;
  logic [PTR_W-1:0] centre;
  logic             behind;
  logic             too_far;

  assign lead    = wr_ptr_i - rd_ptr_i;
  // upper half of the ring counts as behind the reader
  assign behind  = (lead == '0) || lead[PTR_W-1];
  assign too_far = ({1'b0, lead} + CELL_EXT) > {1'b0, max_lead_i};
  assign centre  = rd_ptr_i + (max_lead_i >> 1);

  always_comb begin
    if (!primed_i) begin
      verdict_o = VERD_INIT;
      start_o   = centre;
    end else if (behind) begin
      verdict_o = VERD_UDR;
      start_o   = centre;
    end else if (too_far) begin
      verdict_o = VERD_OVF;
      start_o   = centre;
    end else begin
      verdict_o = VERD_OK;
      start_o   = wr_ptr_i;
    end
  end

  assign next_ptr_o = start_o + CELL_PTR;
endmodule

// File: rtl/jbuf_slip_bank.sv
module jbuf_slip_bank #(
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 11,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CH_W-1:0]  sel_ch_i,
  input  logic             upd_i,
  input  logic [PTR_W-1:0] upd_ptr_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic             primed_o
);
  logic [PTR_W-1:0] ptr_q    [NUM_CH];
  logic [NUM_CH-1:0] primed_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = upd_i && (sel_ch_i == CH_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q[g]    <= '0;
        primed_q[g] <= 1'b0;
      end else if (hit) begin
        ptr_q[g]    <= upd_ptr_i;
        primed_q[g] <= 1'b1;
      end
    end
  end

  assign wr_ptr_o = ptr_q[sel_ch_i];
  assign primed_o = primed_q[sel_ch_i];
endmodule

// File: rtl/jbuf_slip_top.sv
module jbuf_slip_top
  import jbuf_slip_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int PTR_W      = 11,
  parameter int CELL_BYTES = 47,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cell_req_i,
  input  logic [CH_W-1:0]   cell_ch_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  input  logic [PTR_W-1:0]  max_lead_i,
  output logic              wr_vld_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [NUM_CH-1:0] ovf_o,
  output logic [NUM_CH-1:0] udr_o
);
  logic [PTR_W-1:0]  cur_ptr;
  logic              cur_primed;
  verdict_e          verdict;
  logic [PTR_W-1:0]  start;
  logic [PTR_W-1:0]  next_ptr;
  logic [NUM_CH-1:0] ch_sel;

  logic              vld_q;
  logic [PTR_W-1:0]  addr_q;
  logic [NUM_CH-1:0] ovf_q;
  logic [NUM_CH-1:0] udr_q;

  jbuf_slip_bank #(
    .NUM_CH (NUM_CH),
    .PTR_W  (PTR_W)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_ch_i  (cell_ch_i),
    .upd_i     (cell_req_i),
    .upd_ptr_i (next_ptr),
    .wr_ptr_o  (cur_ptr),
    .primed_o  (cur_primed)
  );

  jbuf_slip_class #(
    .PTR_W      (PTR_W),
    .CELL_BYTES (CELL_BYTES)
  ) u_class (
    .primed_i   (cur_primed),
    .wr_ptr_i   (cur_ptr),
    .rd_ptr_i   (rd_ptr_i),
    .max_lead_i (max_lead_i),
    .verdict_o  (verdict),
    .start_o    (start),
    .next_ptr_o (next_ptr)
  );

  assign ch_sel = NUM_CH'(1) << cell_ch_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      ovf_q  <= '0;
      udr_q  <= '0;
    end else begin
      vld_q <= cell_req_i;
      ovf_q <= (cell_req_i && verdict == VERD_OVF) ? ch_sel : '0;
      udr_q <= (cell_req_i && verdict == VERD_UDR) ? ch_sel : '0;
      if (cell_req_i) addr_q <= start;
    end
  end

  assign wr_vld_o  = vld_q;
  assign wr_addr_o = addr_q;
  assign ovf_o     = ovf_q;
  assign udr_o     = udr_q;
endmodule

// File: rtl/jbuf_slip_chk.sv
module jbuf_slip_chk #(
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 11,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cell_req_i,
  input logic [CH_W-1:0]   cell_ch_i,
  input logic [PTR_W-1:0]  rd_ptr_i,
  input logic [PTR_W-1:0]  max_lead_i,
  input logic              wr_vld_o,
  input logic [PTR_W-1:0]  wr_addr_o,
  input logic [NUM_CH-1:0] ovf_o,
  input logic [NUM_CH-1:0] udr_o
);
  logic [PTR_W-1:0]  centre;
  logic [NUM_CH-1:0] req_bit;
  logic [NUM_CH-1:0] err_any;

  assign centre  = rd_ptr_i + (max_lead_i >> 1);
  assign req_bit = NUM_CH'(1) << cell_ch_i;
  assign err_any = ovf_o | udr_o;

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!wr_vld_o && ovf_o == '0 && udr_o == '0));

  assert_err_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_o, udr_o}));

  assert_err_with_vld_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_any != '0) |-> wr_vld_o);

  assert_vld_after_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_req_i |=> wr_vld_o);

  assert_idle_no_vld_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cell_req_i |=> !wr_vld_o);

  assert_slip_recentre_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_req_i |=> (err_any == '0 || wr_addr_o == $past(centre)));

  assert_slip_own_channel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_req_i |=> (err_any == '0 || err_any == $past(req_bit)));
endmodule

bind jbuf_slip_top jbuf_slip_chk #(
  .NUM_CH (NUM_CH),
  .PTR_W  (PTR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cell_req_i (cell_req_i),
  .cell_ch_i  (cell_ch_i),
  .rd_ptr_i   (rd_ptr_i),
  .max_lead_i (max_lead_i),
  .wr_vld_o   (wr_vld_o),
  .wr_addr_o  (wr_addr_o),
  .ovf_o      (ovf_o),
  .udr_o      (udr_o)
);

// File: tb/jbuf_slip_top_tb.sv
module jbuf_slip_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 8;
  localparam int PTR_W      = 11;
  localparam int RING       = 2048;
  localparam int CELL       = 47;
  localparam int CH_W       = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cell_req_i = 1'b0;
  logic [CH_W-1:0]   cell_ch_i = '0;
  logic [PTR_W-1:0]  rd_ptr_i = '0;
  logic [PTR_W-1:0]  max_lead_i = '0;
  logic              wr_vld_o;
  logic [PTR_W-1:0]  wr_addr_o;
  logic [NUM_CH-1:0] ovf_o;
  logic [NUM_CH-1:0] udr_o;

  int n_checks = 0;
  int n_fail   = 0;

  int  m_wr [NUM_CH];
  bit  m_pr [NUM_CH];

  bit                exp_vld  = 1'b0;
  int                exp_addr = 0;
  logic [NUM_CH-1:0] exp_ovf  = '0;
  logic [NUM_CH-1:0] exp_udr  = '0;
  string             exp_tag  = "R1";

  jbuf_slip_top u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cell_req_i (cell_req_i),
    .cell_ch_i  (cell_ch_i),
    .rd_ptr_i   (rd_ptr_i),
    .max_lead_i (max_lead_i),
    .wr_vld_o   (wr_vld_o),
    .wr_addr_o  (wr_addr_o),
    .ovf_o      (ovf_o),
    .udr_o      (udr_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int wrap(input int v);
    return ((v % RING) + RING) % RING;
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  task automatic check_out();
    bit bad;
    n_checks++;
    bad = (wr_vld_o !== exp_vld) || (ovf_o !== exp_ovf) || (udr_o !== exp_udr) ||
          (exp_vld && (int'(wr_addr_o) != exp_addr));
    if (bad) begin
      n_fail++;
      $display("FAIL %s: vld=%0b addr=%0d ovf=%b udr=%b expected vld=%0b addr=%0d ovf=%b udr=%b",
               exp_tag, wr_vld_o, wr_addr_o, ovf_o, udr_o,
               exp_vld, exp_addr, exp_ovf, exp_udr);
    end
  endtask

  // compare the previous cycle's result, then drive and predict the next one
  task automatic step(input bit req, input int ch, input int rd, input int ml, input string tag);
    int lead, centre, start;
    string kind;
    check_out();
    cell_req_i = req;
    cell_ch_i  = CH_W'(ch);
    rd_ptr_i   = PTR_W'(rd);
    max_lead_i = PTR_W'(ml);
    exp_vld = req;
    exp_ovf = '0;
    exp_udr = '0;
    if (req) begin
      centre = wrap(rd + ml / 2);
      lead   = wrap(m_wr[ch] - rd);
      if (!m_pr[ch]) begin
        kind = "R2"; start = centre;
      end else if (lead == 0 || lead >= RING / 2) begin
        kind = "R5"; start = centre; exp_udr[ch] = 1'b1;
      end else if (lead + CELL > ml) begin
        kind = "R4"; start = centre; exp_ovf[ch] = 1'b1;
      end else begin
        kind = "R3"; start = m_wr[ch];
      end
      exp_addr = start;
      m_wr[ch] = wrap(start + CELL);
      m_pr[ch] = 1'b1;
    end else begin
      kind = "R9";
    end
    exp_tag = (tag.len() != 0) ? {tag, "/", kind} : kind;
    @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < NUM_CH; i++) begin
      m_wr[i] = 0;
      m_pr[i] = 1'b0;
    end
    repeat (3) @(negedge clk_i);
    check_out();              // R1 during reset
    rst_ni = 1'b1;
    @(negedge clk_i);

    // ch0: first cell aligns to 100+200=300 (R2)
    step(1, 0, 100, 400, "");
    step(1, 0, 100, 400, "R3");   // lead 247
    step(1, 0, 100, 400, "R3");   // lead 294
    step(1, 0, 100, 400, "R3");   // lead 341, 341+47=388
    step(1, 0, 100, 435, "R3");   // lead 388, 388+47=435 boundary ok
    step(1, 0, 100, 400, "R4");   // lead 435 -> overflow, recentre 300
    step(0, 0, 0, 0, "R6");       // pulse drops after one cycle
    // ch1 near top of ring: wrap R8
    step(1, 1, 2000, 200, "R8");  // start 52
    step(1, 1, 2000, 200, "R8");  // stored 99, lead 147 ok
    step(1, 0, 100, 400, "R7");   // ch0 unaffected: stored 347 lead 247
    step(1, 0, 394, 400, "R5");   // lead 0 -> underrun, start 594
    step(1, 0, 700, 400, "R5");   // writer behind reader
    step(1, 2, 5, 300, "R7");     // ch2 first cell independent
    step(0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, "R9");

    for (int k = 0; k < 3000; k++) begin
      int ch, ml, off;
      ch  = $urandom_range(NUM_CH - 1, 0);
      ml  = $urandom_range(1000, 100);
      off = $urandom_range(ml + 60, 0) - 40;
      if ($urandom_range(4, 0) == 0)
        step(0, 0, 0, 0, "");
      else
        step(1, ch, wrap(m_wr[ch] - off), ml, "");
    end
    step(0, 0, 0, 0, "");
    check_out();
    report();
  end
endmodule